// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Window

This block lets a host reach an internal word-organised SRAM through four directly mapped 32-bit registers. Two of them hold byte pointers, one for reading and one for writing. The other two are data ports. A host access to a data port transfers one 32-bit word to or from the memory word that the matching pointer selects. The pointer then moves forward by four bytes, so a whole block of memory can be streamed without writing the address again.

Reads are served from a one-word prefetch register. Loading the read pointer starts a memory read. Each read of the read-data port hands back the prefetched word, advances the pointer and starts the next read. Writes go through a one-entry holding register that drains to the memory. The memory side is a single-port synchronous interface: a request stays asserted until the memory raises `mem_ready`. The host port stalls through `hst_ready` whenever the data it needs is not there yet, or the holding register is still full.

Top module: `memwin_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_req` is low. After reset both pointers read back as 0 at window offsets 0x0C (read pointer) and 0x10 (write pointer).
- R2: A host write to offset 0x0C or 0x10 loads the full 32-bit value into that pointer, including the two low bits, and a later read of the same offset returns it unchanged.
- R3: A host write to offset 0x18 stores the data in memory word `wptr[MEM_AW+1:2]` and then adds 4 to the write pointer. The two low pointer bits play no part in the memory address.
- R4: A host read of offset 0x1C returns memory word `rptr[MEM_AW+1:2]` and then adds 4 to the read pointer, so consecutive reads return consecutive words.
- R5: Writing the read pointer starts a fresh prefetch. If a prefetch to the old address is still in flight, its result is discarded and the new address is read.
- R6: A read of offset 0x1C while the prefetched word is not yet valid holds `hst_ready` low until the word arrives. A read of 0x1C in the cycle right after a read-pointer load always stalls.
- R7: A write of offset 0x18 while the previous write is still waiting for the memory holds `hst_ready` low. Two data writes can never complete in consecutive cycles.
- R8: When a write and a prefetch are both waiting, the write is issued to memory first. Read data always reflects every earlier host data write, including a write to the word already prefetched.
- R9: Writes to offset 0x1C and to unmapped offsets change no state. Reads of offset 0x18 and of unmapped offsets return 0. If read and write enables are both high, only the write is performed.
- R10: Once `mem_req` is high it stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle in which `mem_ready` is high.
- R11: Pointer increments wrap modulo 2^32: stepping from 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr_en | input | 1 | Host write strobe, held until `hst_ready` |
| hst_rd_en | input | 1 | Host read strobe, held until `hst_ready` |
| hst_addr | input | WIN_AW | Byte offset inside the window |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data, valid when `hst_rd_en` and `hst_ready` are high |
| hst_ready | output | 1 | Access completes at the clock edge where this is high |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current request |

## Verification
The hardest situations to reach are the ones where the host moves the read pointer, or writes the prefetched word, while a memory read is already in flight. A stale word could then be returned. To force these, the bench switches its memory model into a slow mode with a fixed long latency and issues the pointer load, or the colliding data write, in the very next host cycle. Random traffic confined to a small group of words, with random memory latency, then produces many more write-hits on the prefetched word. Every read is compared with a reference memory that the bench updates at the moment of each host write.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int WIN_AW = 6;

  // Window offsets (byte) of the four mapped registers
  localparam logic [WIN_AW-1:0] OFF_RPTR  = 6'h0C;
  localparam logic [WIN_AW-1:0] OFF_WPTR  = 6'h10;
  localparam logic [WIN_AW-1:0] OFF_WDATA = 6'h18;
  localparam logic [WIN_AW-1:0] OFF_RDATA = 6'h1C;

  localparam int PTR_STEP = 4;

  typedef enum logic [2:0] {
    PF_NEED = 3'b001,
    PF_WAIT = 3'b010,
    PF_HAVE = 3'b100
  } pf_state_t;

  typedef enum logic [1:0] {
    MC_IDLE = 2'd0,
    MC_WR   = 2'd1,
    MC_RD   = 2'd2
  } mc_state_t;
endpackage

// File: rtl/memwin_ptrs.sv
module memwin_ptrs #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        load,
  input  logic [1:0]        adv,
  input  logic [W-1:0]      load_val,
  output logic [1:0][W-1:0] ptr
);
  localparam logic [W-1:0] INC = W'(STEP);

  // index 0: read pointer, index 1: write pointer
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[g] <= '0;
      end else if (load[g]) begin
        ptr[g] <= load_val;
      end else if (adv[g]) begin
        ptr[g] <= ptr[g] + INC;
      end
    end
  end
endmodule

// File: rtl/memwin_prefetch.sv
module memwin_prefetch import memwin_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              take,
  input  logic              issue,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output logic              need,
  output logic              have,
  output logic [DATA_W-1:0] data
);
  pf_state_t st;
  logic      stale;

  assign need = (st == PF_NEED);
  assign have = (st == PF_HAVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PF_NEED;
      stale <= 1'b0;
      data  <= '0;
    end else begin
      case (st)
        PF_NEED: begin
          if (issue) begin
            st    <= PF_WAIT;
            stale <= restart;  // address changed under the issued read
          end
        end
        PF_WAIT: begin
          if (done) begin
            stale <= 1'b0;
            if (stale || restart) begin
              st <= PF_NEED;
            end else begin
              st   <= PF_HAVE;
              data <= rdata;
            end
          end else if (restart) begin
            stale <= 1'b1;
          end
        end
        PF_HAVE: begin
          if (restart || take) st <= PF_NEED;
        end
        default: st <= PF_NEED;
      endcase
    end
  end
endmodule

// File: rtl/memwin_wbuf.sv
module memwin_wbuf #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [MEM_AW-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              done,
  output logic              valid,
  output logic [MEM_AW-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      if (done) valid <= 1'b0;
      if (push) begin
        valid <= 1'b1;
        addr  <= push_addr;
        data  <= push_data;
      end
    end
  end
endmodule

// File: rtl/memwin_memctl.sv
module memwin_memctl import memwin_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic [MEM_AW-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              pf_need,
  input  logic [MEM_AW-1:0] rd_word,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              issue_rd,
  output logic              done_rd,
  output logic              done_wr
);
  mc_state_t mc;

  // pending write always wins over a pending prefetch
  assign issue_rd = (mc == MC_IDLE) && !wb_valid && pf_need;
  assign done_wr  = (mc == MC_WR) && mem_ready;
  assign done_rd  = (mc == MC_RD) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc        <= MC_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (mc)
        MC_IDLE: begin
          if (wb_valid) begin
            mc        <= MC_WR;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= wb_addr;
            mem_wdata <= wb_data;
          end else if (pf_need) begin
            mc       <= MC_RD;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_word;
          end
        end
        MC_WR, MC_RD: begin
          if (mem_ready) begin
            mc      <= MC_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
          end
        end
        default: mc <= MC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memwin_top.sv
module memwin_top import memwin_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr_en,
  input  logic              hst_rd_en,
  input  logic [WIN_AW-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int LSB = $clog2(PTR_STEP);

  logic [1:0][DATA_W-1:0] ptr;
  logic [DATA_W-1:0]      rd_ptr, wr_ptr;
  logic [MEM_AW-1:0]      rd_word, wr_word;
  logic sel_rptr, sel_wptr, sel_wdata, sel_rdata;
  logic rd_data_acc, wr_data_acc, take, push, hit, restart;
  logic pf_need, pf_have, wb_valid;
  logic [DATA_W-1:0] pf_data, wb_data;
  logic [MEM_AW-1:0] wb_addr;
  logic issue_rd, done_rd, done_wr;

  assign rd_ptr  = ptr[0];
  assign wr_ptr  = ptr[1];
  assign rd_word = rd_ptr[MEM_AW+LSB-1:LSB];
  assign wr_word = wr_ptr[MEM_AW+LSB-1:LSB];

  assign sel_rptr  = (hst_addr == OFF_RPTR);
  assign sel_wptr  = (hst_addr == OFF_WPTR);
  assign sel_wdata = (hst_addr == OFF_WDATA);
  assign sel_rdata = (hst_addr == OFF_RDATA);

  assign rd_data_acc = hst_rd_en && !hst_wr_en && sel_rdata;
  assign wr_data_acc = hst_wr_en && sel_wdata;
  assign take        = rd_data_acc && pf_have;
  assign push        = wr_data_acc && !wb_valid;
  // a write landing on the prefetched word forces a refetch behind it
  assign hit         = push && (wr_word == rd_word);
  assign restart     = (hst_wr_en && sel_rptr) || hit;

  assign hst_ready = !(rd_data_acc && !pf_have) && !(wr_data_acc && wb_valid);

  always_comb begin
    hst_rdata = '0;
    if (sel_rptr)       hst_rdata = rd_ptr;
    else if (sel_wptr)  hst_rdata = wr_ptr;
    else if (sel_rdata) hst_rdata = pf_data;
  end

  memwin_ptrs #(.W(DATA_W), .STEP(PTR_STEP)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .load     ({hst_wr_en && sel_wptr, hst_wr_en && sel_rptr}),
    .adv      ({push, take}),
    .load_val (hst_wdata),
    .ptr      (ptr)
  );

  memwin_prefetch #(.DATA_W(DATA_W)) u_pf (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .take    (take),
    .issue   (issue_rd),
    .done    (done_rd),
    .rdata   (mem_rdata),
    .need    (pf_need),
    .have    (pf_have),
    .data    (pf_data)
  );

  memwin_wbuf #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_wb (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (wr_word),
    .push_data (hst_wdata),
    .done      (done_wr),
    .valid     (wb_valid),
    .addr      (wb_addr),
    .data      (wb_data)
  );

  memwin_memctl #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mc (
    .clk       (clk),
    .rst       (rst),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .pf_need   (pf_need),
    .rd_word   (rd_word),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .issue_rd  (issue_rd),
    .done_rd   (done_rd),
    .done_wr   (done_wr)
  );
endmodule

// File: rtl/memwin_chk.sv
module memwin_chk import memwin_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_wr_en,
  input logic              hst_rd_en,
  input logic [WIN_AW-1:0] hst_addr,
  input logic              hst_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              wb_valid,
  input logic [DATA_W-1:0] rd_ptr
);
  logic rdat_done, wdat_done;
  assign rdat_done = hst_rd_en && !hst_wr_en && (hst_addr == OFF_RDATA) && hst_ready;
  assign wdat_done = hst_wr_en && (hst_addr == OFF_WDATA) && hst_ready;

  p_rst_idle_r1: assert property (@(posedge clk) rst |=> !mem_req);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_write_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && !mem_we |-> !$past(wb_valid));

  p_rdat_stall_r6: assert property (@(posedge clk) disable iff (rst)
    hst_wr_en && (hst_addr == OFF_RPTR) |=> !rdat_done);

  p_wdat_stall_r7: assert property (@(posedge clk) disable iff (rst)
    wdat_done |=> !wdat_done);

  p_rptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    rdat_done |=> rd_ptr == $past(rd_ptr) + DATA_W'(PTR_STEP));
endmodule

bind memwin_top memwin_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hst_wr_en (hst_wr_en),
  .hst_rd_en (hst_rd_en),
  .hst_addr  (hst_addr),
  .hst_ready (hst_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .wb_valid  (wb_valid),
  .rd_ptr    (rd_ptr)
);

// File: tb/test_memwin_top.sv
module test_memwin_top;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam logic [5:0] O_RP = 6'h0C, O_WP = 6'h10, O_WD = 6'h18, O_RD = 6'h1C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic hst_wr_en = 1'b0, hst_rd_en = 1'b0;
  logic [5:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic hst_ready, mem_req, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  memwin_top #(.DATA_W(32), .MEM_AW(MEM_AW)) i_memwin_top (.*);

  logic [31:0] mem_model [DEPTH];
  logic [31:0] ref_mem [DEPTH];
  logic [31:0] ref_rp = '0, ref_wp = '0;
  int total = 0, bad = 0;
  bit slow = 0, finished = 0;
  int wait_left = -1;
  bit hold_seen = 0;
  logic [MEM_AW-1:0] hold_addr;
  logic hold_we;
  logic [31:0] hold_wdata;

  function automatic logic [31:0] seed_word(int i);
    return (32'h9E3779B9 * (i + 1)) ^ 32'h5A5A0000;
  endfunction

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) & (DEPTH - 1));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with random (or fixed slow) latency
  always @(negedge clk) begin
    if (hold_seen) begin
      check("R10 hold", {mem_req, mem_we, mem_addr == hold_addr, mem_wdata == hold_wdata},
            {1'b1, hold_we, 1'b1, 1'b1});
      hold_seen = 0;
    end
    mem_ready = 1'b0;
    if (!rst && mem_req) begin
      if (wait_left < 0) wait_left = slow ? 6 : int'($urandom % 3);
      if (wait_left == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mem_model[mem_addr];
      end else begin
        wait_left--;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ready) begin
      if (mem_we) mem_model[mem_addr] = mem_wdata;
      wait_left = -1;
    end else if (!rst && mem_req && !mem_ready) begin
      hold_seen = 1; hold_addr = mem_addr; hold_we = mem_we; hold_wdata = mem_wdata;
    end
  end

  task automatic host_acc(input bit wr, input logic [5:0] off, input logic [31:0] wd,
                          output logic [31:0] rd, output int waited);
    @(negedge clk);
    hst_wr_en = wr; hst_rd_en = !wr; hst_addr = off; hst_wdata = wd; waited = 0;
    #1;
    while (!hst_ready) begin
      waited++;
      @(negedge clk); #1;
    end
    rd = hst_rdata;
    @(posedge clk); #1;
    hst_wr_en = 0; hst_rd_en = 0;
  endtask

  task automatic wr_reg(input logic [5:0] off, input logic [31:0] d, output int waited);
    logic [31:0] dummy;
    host_acc(1, off, d, dummy, waited);
    if (off == O_RP) ref_rp = d;
    else if (off == O_WP) ref_wp = d;
    else if (off == O_WD) begin ref_mem[widx(ref_wp)] = d; ref_wp += 4; end
  endtask

  task automatic rd_data(input string req, output int waited);
    logic [31:0] v;
    host_acc(0, O_RD, '0, v, waited);
    check(req, v, ref_mem[widx(ref_rp)]);
    ref_rp += 4;
  endtask

  task automatic rd_reg(input string req, input logic [5:0] off, input logic [31:0] exp);
    logic [31:0] v;
    int w;
    host_acc(0, off, '0, v, w);
    check(req, v, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w;
    for (int i = 0; i < DEPTH; i++) begin
      mem_model[i] = seed_word(i);
      ref_mem[i]   = seed_word(i);
    end
    repeat (4) @(negedge clk);
    check("R1 reset req", {31'd0, mem_req}, 32'd0);
    @(negedge clk); rst = 0;
    check("R1 first cycle req", {31'd0, mem_req}, 32'd0);
    rd_reg("R1 rptr", O_RP, 32'd0);
    rd_reg("R1 wptr", O_WP, 32'd0);

    // R2 pointer readback with low bits
    wr_reg(O_RP, 32'h1234_5677, w);
    rd_reg("R2 rptr", O_RP, 32'h1234_5677);
    wr_reg(O_WP, 32'hABCD_EF02, w);
    rd_reg("R2 wptr", O_WP, 32'hABCD_EF02);

    // R3 stream writes, low bits ignored
    wr_reg(O_WP, 32'h0000_0043, w);
    for (int i = 0; i < 4; i++) wr_reg(O_WD, 32'hC0DE_0000 + i, w);
    rd_reg("R3 wptr step", O_WP, 32'h0000_0053);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) check("R3 mem word", mem_model[16 + i], 32'hC0DE_0000 + i);

    // R4 stream reads
    wr_reg(O_RP, 32'h0000_0041, w);
    for (int i = 0; i < 6; i++) rd_data("R4 stream", w);
    rd_reg("R4 rptr step", O_RP, 32'h0000_0059);

    // R11 wrap
    wr_reg(O_RP, 32'hFFFF_FFFC, w);
    rd_data("R11 last word", w);
    rd_reg("R11 wrap", O_RP, 32'h0000_0000);

    // R6 / R7 / R5 with slow memory
    slow = 1;
    wr_reg(O_RP, 32'h0000_0100, w);
    rd_data("R6 data", w);
    check("R6 stalled", {31'd0, w > 0}, 32'd1);
    wr_reg(O_WP, 32'h0000_0200, w);
    wr_reg(O_WD, 32'h1111_1111, w);
    wr_reg(O_WD, 32'h2222_2222, w);
    check("R7 stalled", {31'd0, w > 0}, 32'd1);
    wr_reg(O_RP, 32'h0000_0300, w);
    wr_reg(O_RP, 32'h0000_0310, w);
    rd_data("R5 restart in flight", w);
    rd_reg("R5 rptr", O_RP, 32'h0000_0314);

    // R8 write to prefetched word, slow then fast
    for (int k = 0; k < 2; k++) begin
      wr_reg(O_WP, 32'h0000_0080, w);
      wr_reg(O_RP, 32'h0000_0080, w);
      if (k == 1) repeat (10) @(negedge clk);
      wr_reg(O_WD, 32'hFEED_0000 + k, w);
      rd_data("R8 coherent", w);
      check("R8 new value", ref_mem[32], 32'hFEED_0000 + k);
      slow = 0;
    end

    // R9 ignored writes and zero reads
    wr_reg(O_RP, 32'h0000_0400, w);
    wr_reg(O_RD, 32'hDEAD_BEEF, w);
    wr_reg(6'h00, 32'hDEAD_BEEF, w);
    wr_reg(6'h20, 32'hDEAD_BEEF, w);
    rd_reg("R9 rptr kept", O_RP, 32'h0000_0400);
    rd_data("R9 data kept", w);
    rd_reg("R9 wdata reads 0", O_WD, 32'd0);
    rd_reg("R9 unmapped reads 0", 6'h14, 32'd0);
    @(negedge clk);
    hst_wr_en = 1; hst_rd_en = 1; hst_addr = O_RP; hst_wdata = 32'h0000_0044;
    @(posedge clk); #1; hst_wr_en = 0; hst_rd_en = 0; ref_rp = 32'h0000_0044;
    rd_reg("R9 both enables", O_RP, 32'h0000_0044);

    // random traffic on a small group of words
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] a;
      op = int'($urandom % 6);
      a  = {24'd0, 2'd0, 4'($urandom), 2'($urandom)};
      case (op)
        0: wr_reg(O_RP, a, w);
        1: wr_reg(O_WP, a, w);
        2, 3: wr_reg(O_WD, $urandom, w);
        4: rd_data("R4 random", w);
        default: begin
          rd_reg("R2 random rptr", O_RP, ref_rp);
          rd_reg("R2 random wptr", O_WP, ref_wp);
        end
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule